// File: doc/BRIEF.md
# Serial Configuration Command Port

This block is the configuration front end of a multi-channel readout chip. A controller sends short serial command frames on a data line, clocked by a serial clock, and framed by an active-high frame-enable. Every frame opens with a 13-bit header that names a chip, a target register and an operation. Several chips can share the same serial lines, so a chip acts only on a header whose chip field equals its strapped identity inputs.

The register bank has five registers of 2, 8 and 128 bits:
- a two-bit shaping-time selector;
- a 128-bit per-channel kill mask;
- a 128-bit per-channel test-inject mask;
- an output-line selector;
- a run-control byte that holds the send-data, reject-hits and reset controls.

An operation can write new contents serially or read the contents back on a serial output. It can also fill every bit with ones, clear every bit to zero, or reload the register's built-in default.

Top module: `slow_ctl_port`

## Requirements
- R1: After asynchronous reset (rst_n low), shape_sel is 2'b01, kill_mask is all zeros, inject_mask is all zeros, line_sel is 8'h01 and run_ctl is 8'h00. Reloading a register's default gives these same values.
- R2: Bits are sampled on the rising edge of sclk while sfrm is high, most significant bit first. The header is 13 bits: chip field [12:8], address [7:3], opcode [2:0]. Any rising edge with sfrm low returns the port to header reception, and after such an edge sdo is low.
- R3: When the header's chip field differs from chip_id, the frame changes no register and sdo stays low.
- R4: Opcode 0 writes. The address map is 0 for shape_sel (2 bits), 1 for kill_mask (128 bits), 2 for inject_mask (128 bits), 3 for line_sel (8 bits) and 4 for run_ctl (8 bits). The data bits follow the header, most significant bit first. The register takes the new value on the edge that samples the last data bit, and sdo stays low during a write.
- R5: Opcode 1 reads. After the edge that samples the last header bit, sdo shows the register's most significant bit. Each further rising edge moves sdo to the next lower bit, until all of the register's bits have been shown.
- R6: Opcode 2 sets every bit of the addressed register to 1 on the last header edge.
- R7: Opcode 3 clears every bit of the addressed register to 0 on the last header edge.
- R8: Opcode 4 loads the addressed register with its default value (see R1) on the last header edge.
- R9: Addresses 5 to 31 and opcodes 5 to 7 change no register, and for these sdo stays low.
- R10: A write frame that ends (sfrm low) before its last data bit is sampled leaves the register unchanged.
- R11: A frame changes at most the one register it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfrm | input | 1 | Frame enable, high for the length of a command |
| sdi | input | 1 | Serial command and write data |
| chip_id | input | 5 | Strapped chip identity |
| sdo | output | 1 | Serial read data, low when not reading |
| shape_sel | output | 2 | Shaping-time setting, one of four |
| kill_mask | output | 128 | Per-channel discriminator disable |
| inject_mask | output | 128 | Per-channel test-pulse enable |
| line_sel | output | 8 | Output serial-line selection |
| run_ctl | output | 8 | Send-data, reject-hits and reset controls |

## Verification
Two events can land on the same rising edge: a frame ending and the final data bit of a write arriving. The bench drops sfrm exactly on the edge that would have carried the last line_sel bit. It then checks that line_sel still holds its old value. A later complete write to the same register must take effect, which shows that the abort left the port ready for the next header. Read-back bits go through a scoreboard that is sampled on falling edges. For rejected frames, the expected value on sdo is zeros.

// File: rtl/slow_ctl_port.sv
module slow_ctl_port #(
  parameter int ID_W = 5,
  parameter int ADDR_W = 5,
  parameter int OP_W = 3,
  parameter int NCH = 128,
  parameter int SHAPE_W = 2,
  parameter int BYTE_W = 8,
  parameter logic [1:0] SHAPE_DEF = 2'b01,
  parameter logic [7:0] LINE_DEF = 8'h01,
  parameter logic [7:0] CTL_DEF = 8'h00
) (
  input  logic                 sclk,
  input  logic                 rst_n,
  input  logic                 sfrm,
  input  logic                 sdi,
  input  logic [ID_W-1:0]      chip_id,
  output logic                 sdo,
  output logic [SHAPE_W-1:0]   shape_sel,
  output logic [NCH-1:0]       kill_mask,
  output logic [NCH-1:0]       inject_mask,
  output logic [BYTE_W-1:0]    line_sel,
  output logic [BYTE_W-1:0]    run_ctl
);
  localparam int HDR_W = ID_W + ADDR_W + OP_W;
  localparam int LEN_MAX = (NCH > HDR_W) ? NCH : HDR_W;
  localparam int CNT_W = $clog2(LEN_MAX) + 1;

  typedef enum logic [1:0] {S_HDR, S_WR, S_RD, S_IGN} st_t;
  st_t st;
  logic [CNT_W-1:0]  cnt;
  logic [HDR_W-2:0]  hdr_sh;
  logic [ADDR_W-1:0] tgt;
  logic [NCH-1:0]    dsh, rd_sh, cur_val, upd_val;
  logic [ADDR_W-1:0] upd_addr;
  logic              upd_en;

  wire [HDR_W-1:0]  frame  = {hdr_sh, sdi};
  wire              id_ok  = frame[HDR_W-1 -: ID_W] == chip_id;
  wire [ADDR_W-1:0] f_addr = frame[OP_W +: ADDR_W];
  wire [OP_W-1:0]   f_op   = frame[OP_W-1:0];
  wire [NCH-1:0]    dnext  = {dsh[NCH-2:0], sdi};
  wire              hdr_end = sfrm && st == S_HDR && cnt == CNT_W'(HDR_W-1);

  function automatic logic [CNT_W-1:0] len_of(input logic [ADDR_W-1:0] a);
    case (a)
      0:       return CNT_W'(SHAPE_W);
      1, 2:    return CNT_W'(NCH);
      3, 4:    return CNT_W'(BYTE_W);
      default: return '0;
    endcase
  endfunction

  function automatic logic [NCH-1:0] dflt_of(input logic [ADDR_W-1:0] a);
    case (a)
      0:       return NCH'(SHAPE_DEF);
      3:       return NCH'(LINE_DEF);
      4:       return NCH'(CTL_DEF);
      default: return '0;
    endcase
  endfunction

  wire [CNT_W-1:0] tgt_len = len_of(tgt);
  wire [CNT_W-1:0] f_len   = len_of(f_addr);

  always_comb begin
    case (f_addr)
      0:       cur_val = NCH'(shape_sel);
      1:       cur_val = kill_mask;
      2:       cur_val = inject_mask;
      3:       cur_val = NCH'(line_sel);
      4:       cur_val = NCH'(run_ctl);
      default: cur_val = '0;
    endcase
  end

  always_comb begin
    upd_en = 1'b0;
    upd_addr = f_addr;
    upd_val = '0;
    if (hdr_end && id_ok && f_len != 0) begin
      case (f_op)
        3'd2: begin upd_en = 1'b1; upd_val = '1; end
        3'd3: begin upd_en = 1'b1; upd_val = '0; end
        3'd4: begin upd_en = 1'b1; upd_val = dflt_of(f_addr); end
        default: ;
      endcase
    end else if (sfrm && st == S_WR && cnt == tgt_len - 1'b1) begin
      upd_en = 1'b1;
      upd_addr = tgt;
      upd_val = dnext;
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_HDR;
      cnt <= '0;
      hdr_sh <= '0;
      tgt <= '0;
      dsh <= '0;
      rd_sh <= '0;
    end else if (!sfrm) begin
      st <= S_HDR;
      cnt <= '0;
    end else begin
      case (st)
        S_HDR: begin
          hdr_sh <= frame[HDR_W-2:0];
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(HDR_W-1)) begin
            cnt <= '0;
            tgt <= f_addr;
            st <= S_IGN;
            if (id_ok && f_len != 0) begin
              if (f_op == 3'd0) st <= S_WR;
              if (f_op == 3'd1) begin
                st <= S_RD;
                rd_sh <= cur_val << (CNT_W'(NCH) - f_len);
              end
            end
          end
        end
        S_WR: begin
          dsh <= dnext;
          cnt <= cnt + 1'b1;
          if (cnt == tgt_len - 1'b1) st <= S_IGN;
        end
        S_RD: begin
          rd_sh <= rd_sh << 1;
          cnt <= cnt + 1'b1;
          if (cnt == tgt_len - 1'b1) st <= S_IGN;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      shape_sel <= SHAPE_DEF;
      kill_mask <= '0;
      inject_mask <= '0;
      line_sel <= LINE_DEF;
      run_ctl <= CTL_DEF;
    end else if (upd_en) begin
      case (upd_addr)
        0: shape_sel <= upd_val[SHAPE_W-1:0];
        1: kill_mask <= upd_val;
        2: inject_mask <= upd_val;
        3: line_sel <= upd_val[BYTE_W-1:0];
        4: run_ctl <= upd_val[BYTE_W-1:0];
        default: ;
      endcase
    end
  end

  assign sdo = (st == S_RD) && rd_sh[NCH-1];

  assert_idle_stable_R10: assert property (@(posedge sclk) disable iff (!rst_n)
    !sfrm |=> ($stable(kill_mask) && $stable(inject_mask) && $stable(shape_sel)
               && $stable(line_sel) && $stable(run_ctl)));
  assert_single_target_R11: assert property (@(posedge sclk) disable iff (!rst_n)
    $stable(kill_mask) || $stable(inject_mask));
  assert_sdo_quiet_R2: assert property (@(posedge sclk) disable iff (!rst_n)
    !sfrm |=> !sdo);
  assert_write_silent_R4: assert property (@(posedge sclk) disable iff (!rst_n)
    (st == S_WR) |-> !sdo);
  assert_foreign_id_R3: assert property (@(posedge sclk) disable iff (!rst_n)
    (hdr_end && !id_ok) |=> ($stable(kill_mask) && $stable(inject_mask)
      && $stable(shape_sel) && $stable(line_sel) && $stable(run_ctl) && !sdo));
endmodule

// File: tb/sim_slow_ctl_port.sv
module sim_slow_ctl_port;
  localparam int PER = 10;
  localparam logic [4:0] MYID = 5'h13;

  logic sclk = 1'b0, rst_n = 1'b0, sfrm = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [1:0] shape_sel;
  logic [127:0] kill_mask, inject_mask;
  logic [7:0] line_sel, run_ctl;
  int n_chk = 0, n_fail = 0;
  logic exp_q[$];
  string cur_tag = "";
  event smp;

  always #(PER/2) sclk = ~sclk;

  slow_ctl_port u0 (.sclk(sclk), .rst_n(rst_n), .sfrm(sfrm), .sdi(sdi), .chip_id(MYID),
    .sdo(sdo), .shape_sel(shape_sel), .kill_mask(kill_mask), .inject_mask(inject_mask),
    .line_sel(line_sel), .run_ctl(run_ctl));

  always @(smp) begin
    logic e;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 1'b0;
    n_chk++;
    if (sdo !== e) begin
      n_fail++;
      $display("FAIL %s sdo act=%b exp=%b", cur_tag, sdo, e);
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    @(negedge sclk); sfrm = 1'b1; sdi = b;
  endtask

  task automatic hdr(input logic [4:0] id, input logic [4:0] a, input logic [2:0] op);
    logic [12:0] w;
    w = {id, a, op};
    for (int i = 12; i >= 0; i--) bit_out(w[i]);
  endtask

  task automatic end_frame();
    @(negedge sclk); sfrm = 1'b0; sdi = 1'b0;
    @(negedge sclk);
  endtask

  task automatic wr(input logic [4:0] id, input logic [4:0] a, input int len, input logic [127:0] v);
    hdr(id, a, 3'd0);
    for (int i = len - 1; i >= 0; i--) bit_out(v[i]);
    end_frame();
  endtask

  task automatic rd(input logic [4:0] id, input logic [4:0] a, input int len,
                    input logic [127:0] v, input string tag);
    cur_tag = tag;
    for (int i = len - 1; i >= 0; i--) exp_q.push_back(v[i]);
    hdr(id, a, 3'd1);
    for (int k = 0; k < len; k++) begin
      @(negedge sclk); sdi = 1'b0; ->smp;
    end
    end_frame();
  endtask

  task automatic op_only(input logic [4:0] id, input logic [4:0] a, input logic [2:0] op);
    hdr(id, a, op);
    end_frame();
  endtask

  initial begin
    #(PER * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] pat;
    for (int i = 0; i < 128; i++) pat[i] = ((i * 7) % 5 == 0) ^ (i[3]);
    #(PER * 3); @(negedge sclk); rst_n = 1'b1; @(negedge sclk);
    chk("R1 shape", 128'(shape_sel), 128'h1);
    chk("R1 kill", kill_mask, '0);
    chk("R1 inject", inject_mask, '0);
    chk("R1 line", 128'(line_sel), 128'h1);
    chk("R1 ctl", 128'(run_ctl), '0);
    chk("R2 sdo idle", 128'(sdo), '0);
    wr(MYID, 5'd0, 2, 128'h2);
    chk("R4 shape write", 128'(shape_sel), 128'h2);
    wr(MYID, 5'd1, 128, pat);
    chk("R4 kill write", kill_mask, pat);
    chk("R11 inject untouched", inject_mask, '0);
    rd(MYID, 5'd1, 128, pat, "R5 kill read");
    rd(MYID, 5'd0, 2, 128'h2, "R5 shape read");
    wr(5'h07, 5'd3, 8, 128'h5A);
    chk("R3 foreign write", 128'(line_sel), 128'h1);
    rd(5'h07, 5'd1, 8, '0, "R3 foreign read");
    op_only(MYID, 5'd2, 3'd2);
    chk("R6 inject set", inject_mask, '1);
    chk("R11 kill kept", kill_mask, pat);
    op_only(MYID, 5'd1, 3'd3);
    chk("R7 kill clear", kill_mask, '0);
    wr(MYID, 5'd3, 8, 128'hA5);
    chk("R4 line write", 128'(line_sel), 128'hA5);
    op_only(MYID, 5'd3, 3'd4);
    chk("R8 line default", 128'(line_sel), 128'h1);
    op_only(MYID, 5'd0, 3'd4);
    chk("R8 shape default", 128'(shape_sel), 128'h1);
    wr(MYID, 5'd4, 8, 128'h3C);
    chk("R4 ctl write", 128'(run_ctl), 128'h3C);
    op_only(MYID, 5'd4, 3'd2);
    chk("R6 ctl set", 128'(run_ctl), 128'hFF);
    wr(MYID, 5'd9, 8, 128'hFF);
    rd(MYID, 5'd9, 8, '0, "R9 unmapped read");
    op_only(MYID, 5'd4, 3'd6);
    chk("R9 nop opcode", 128'(run_ctl), 128'hFF);
    chk("R9 unmapped line", 128'(line_sel), 128'h1);
    hdr(MYID, 5'd3, 3'd0);
    for (int i = 7; i >= 1; i--) bit_out(1'b0);
    end_frame();
    chk("R10 aborted write", 128'(line_sel), 128'h1);
    wr(MYID, 5'd3, 8, 128'h06);
    chk("R10 next frame ok", 128'(line_sel), 128'h06);
    rd(MYID, 5'd3, 8, 128'h06, "R5 line read");
    rd(MYID, 5'd2, 128, '1, "R5 inject read");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule